// File: doc/BRIEF.md
# SONET/SDH Pointer Byte Transmit Inserter

This block supplies the nine pointer-related overhead bytes (three H1, three H2, three H3) of a concatenated 155 Mb/s transmit frame. An external frame counter tells it which of the nine slots is current by presenting a slot index and a strobe. The block answers one clock later with the byte to place in that slot and a valid flag. The pointer value is fixed so that the path overhead J1 byte follows the Z0 bytes at once, and the concatenation indicator fills the second and third H1/H2 columns.

Three controls shape the bytes. A coding select picks SONET or SDH coding of the first H1 byte. A line AIS force turns every pointer slot into all-ones. An invalid-pointer force replaces the first H1 and the first H2 byte with 0x33. A small state machine samples the controls only at the first slot of each frame, so one frame never mixes normal and overridden bytes. Its states are NORMAL, AIS and BADPTR. On every frame-start strobe it moves to AIS if the AIS force is high, otherwise to BADPTR if the invalid-pointer force is high, otherwise to NORMAL. It holds its state between frame starts. The frame-start slot already uses the newly chosen state.

Top module: `ptr_byte_inserter`

## Requirements
- R1: A strobe with slot index 0 to 8 gives out_vld high one clock later. A strobe with index 9 to 15 is ignored: out_vld stays low and out_byte keeps its value.
- R2: Slot 0 (first H1) carries 0x62 when the frame's coding select is 0 (SONET) and 0x6A when it is 1 (SDH).
- R3: Slots 1 and 2 (second and third H1) carry 0x93, and slot 3 (first H2) carries 0x0A, under both codings.
- R4: Slots 4 and 5 (second and third H2) carry 0xFF, and slots 6, 7 and 8 (H3) carry 0x00.
- R5: In a frame whose AIS force was high at slot 0, all nine slots carry 0xFF.
- R6: In a frame whose invalid-pointer force was high at slot 0 (and AIS low), slots 0 and 3 carry 0x33, and the other slots keep their normal values.
- R7: When both forces are high at slot 0, AIS wins and every slot carries 0xFF.
- R8: The coding select and both forces are sampled only on a strobe with slot index 0. A change at any later slot takes effect from the next frame.
- R9: Without a strobe, out_vld is low on the next clock and out_byte holds its last value.
- R10: After reset, out_vld and out_byte are 0. Until the first slot-0 strobe, the frame state is NORMAL with SONET coding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_vld | input | 1 | Strobe: slot_idx names the current pointer slot |
| slot_idx | input | 4 | Pointer slot index, 0 to 8 |
| sdh_mode | input | 1 | Coding select: 0 SONET, 1 SDH (sampled at slot 0) |
| ais_force | input | 1 | Force all-ones in every pointer slot (sampled at slot 0) |
| badptr_force | input | 1 | Force 0x33 into slots 0 and 3 (sampled at slot 0) |
| out_byte | output | 8 | Byte to place in the strobed slot |
| out_vld | output | 1 | out_byte belongs to the slot strobed one clock earlier |

## Verification
Every result of this block is due exactly one clock after the strobe that requests it. That applies to the byte, the valid flag and the choice of frame state made at slot 0. The bench drives inputs on the falling edge and runs its reference model on the same inputs, so the model's prediction is ready for the next falling edge. It compares out_vld and out_byte there, one rising edge after the stimulus, on every clock, including idle and out-of-range cycles where it expects the byte to hold.

// File: rtl/ptr_ins_pkg.sv
package ptr_ins_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FM_NORMAL = 2'd0,
        FM_AIS    = 2'd1,
        FM_BADPTR = 2'd2
    } frame_mode_e;

    localparam logic [BYTE_W-1:0] H1_SONET  = 8'h62;
    localparam logic [BYTE_W-1:0] H1_SDH    = 8'h6A;
    localparam logic [BYTE_W-1:0] CONCAT_H1 = 8'h93;
    localparam logic [BYTE_W-1:0] H2_FIRST  = 8'h0A;
    localparam logic [BYTE_W-1:0] CONCAT_H2 = 8'hFF;
    localparam logic [BYTE_W-1:0] H3_IDLE   = 8'h00;
    localparam logic [BYTE_W-1:0] ALL_ONES  = 8'hFF;
    localparam logic [BYTE_W-1:0] BAD_PTR   = 8'h33;

endpackage

// File: rtl/ptr_frame_fsm.sv
module ptr_frame_fsm
    import ptr_ins_pkg::*;
#(
    parameter int SLOT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              sdh_mode,
    input  logic              ais_force,
    input  logic              badptr_force,
    output frame_mode_e       cur_mode,
    output logic              cur_sdh
);

    frame_mode_e state_q, state_d, pick;
    logic        sdh_q;
    logic        frame_start;

    assign frame_start = slot_vld && (slot_idx == '0);

    // Control choice made at frame start
    always_comb begin
        if (ais_force)         pick = FM_AIS;
        else if (badptr_force) pick = FM_BADPTR;
        else                   pick = FM_NORMAL;
    end

    // Transitions: every state moves on a frame start, holds otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FM_NORMAL: if (frame_start) state_d = pick;
            FM_AIS:    if (frame_start) state_d = pick;
            FM_BADPTR: if (frame_start) state_d = pick;
            default:   state_d = FM_NORMAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FM_NORMAL;
            sdh_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (frame_start) sdh_q <= sdh_mode;
        end
    end

    // The frame-start slot already uses the fresh choice
    always_comb begin
        cur_mode = frame_start ? state_d : state_q;
        cur_sdh  = frame_start ? sdh_mode : sdh_q;
    end

endmodule

// File: rtl/ptr_slot_lut.sv
module ptr_slot_lut
    import ptr_ins_pkg::*;
#(
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 9
) (
    input  logic [SLOT_W-1:0] slot_idx,
    input  frame_mode_e       mode,
    input  logic              sdh,
    output logic [BYTE_W-1:0] byte_o,
    output logic              in_range
);

    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_SLOTS - 1);

    logic [BYTE_W-1:0] normal_byte;

    assign in_range = (slot_idx <= LAST_SLOT);

    always_comb begin
        unique case (slot_idx)
            SLOT_W'(0): normal_byte = sdh ? H1_SDH : H1_SONET;
            SLOT_W'(1),
            SLOT_W'(2): normal_byte = CONCAT_H1;
            SLOT_W'(3): normal_byte = H2_FIRST;
            SLOT_W'(4),
            SLOT_W'(5): normal_byte = CONCAT_H2;
            default:    normal_byte = H3_IDLE;
        endcase
    end

    always_comb begin
        unique case (mode)
            FM_AIS:    byte_o = ALL_ONES;
            FM_BADPTR: byte_o = ((slot_idx == SLOT_W'(0)) || (slot_idx == SLOT_W'(3)))
                                ? BAD_PTR : normal_byte;
            default:   byte_o = normal_byte;
        endcase
    end

endmodule

// File: rtl/ptr_byte_inserter.sv
module ptr_byte_inserter
    import ptr_ins_pkg::*;
#(
    parameter int SLOT_W    = 4,
    parameter int NUM_SLOTS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_vld,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              sdh_mode,
    input  logic              ais_force,
    input  logic              badptr_force,
    output logic [BYTE_W-1:0] out_byte,
    output logic              out_vld
);

    frame_mode_e       mode;
    logic              sdh;
    logic [BYTE_W-1:0] lut_byte;
    logic              in_range;

    ptr_frame_fsm #(.SLOT_W(SLOT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_vld     (slot_vld),
        .slot_idx     (slot_idx),
        .sdh_mode     (sdh_mode),
        .ais_force    (ais_force),
        .badptr_force (badptr_force),
        .cur_mode     (mode),
        .cur_sdh      (sdh)
    );

    ptr_slot_lut #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_lut (
        .slot_idx (slot_idx),
        .mode     (mode),
        .sdh      (sdh),
        .byte_o   (lut_byte),
        .in_range (in_range)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_byte <= '0;
            out_vld  <= 1'b0;
        end else begin
            out_vld <= slot_vld && in_range;
            if (slot_vld && in_range) out_byte <= lut_byte;
        end
    end

endmodule

// File: rtl/ptr_ins_chk.sv
module ptr_ins_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       slot_vld,
    input logic [3:0] slot_idx,
    input logic       ais_force,
    input logic       badptr_force,
    input logic [7:0] out_byte,
    input logic       out_vld
);

    // R1
    vld_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld == $past(slot_vld && (slot_idx <= 4'd8)));

    // R5
    ais_all_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_idx == 4'd0 && ais_force) |=> (out_byte == 8'hFF));

    // R6
    badptr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_vld && slot_idx == 4'd0 && !ais_force && badptr_force) |=> (out_byte == 8'h33));

    // R9
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_vld |=> (!out_vld && $stable(out_byte)));

    // R4
    legal_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> (out_byte inside {8'h00, 8'h0A, 8'h33, 8'h62, 8'h6A, 8'h93, 8'hFF}));

endmodule

bind ptr_byte_inserter ptr_ins_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .slot_vld     (slot_vld),
    .slot_idx     (slot_idx),
    .ais_force    (ais_force),
    .badptr_force (badptr_force),
    .out_byte     (out_byte),
    .out_vld      (out_vld)
);

// File: tb/ptr_byte_inserter_test.sv
`timescale 1ns/1ps
module ptr_byte_inserter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       slot_vld = 1'b0;
    logic [3:0] slot_idx = '0;
    logic       sdh_mode = 1'b0;
    logic       ais_force = 1'b0;
    logic       badptr_force = 1'b0;
    logic [7:0] out_byte;
    logic       out_vld;

    int total = 0;
    int bad = 0;

    // reference model state
    bit         lat_ais = 0, lat_bad = 0, lat_sdh = 0;
    bit         exp_vld = 0;
    logic [7:0] exp_byte = 8'h00;
    string      exp_tag = "R10";

    always #2.5 clk = ~clk;

    ptr_byte_inserter uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .slot_vld     (slot_vld),
        .slot_idx     (slot_idx),
        .sdh_mode     (sdh_mode),
        .ais_force    (ais_force),
        .badptr_force (badptr_force),
        .out_byte     (out_byte),
        .out_vld      (out_vld)
    );

    function automatic logic [7:0] ref_byte(int idx);
        if (lat_ais) return 8'hFF;
        if (lat_bad && (idx == 0 || idx == 3)) return 8'h33;
        if (idx == 0) return lat_sdh ? 8'h6A : 8'h62;
        if (idx == 1 || idx == 2) return 8'h93;
        if (idx == 3) return 8'h0A;
        if (idx == 4 || idx == 5) return 8'hFF;
        return 8'h00;
    endfunction

    task automatic compare();
        total++;
        if (out_vld !== exp_vld || out_byte !== exp_byte) begin
            bad++;
            $display("FAIL %s: vld=%0b byte=%02h expected vld=%0b byte=%02h",
                     exp_tag, out_vld, out_byte, exp_vld, exp_byte);
        end
    endtask

    // check previous result, apply new inputs, predict the next result
    task automatic drive(bit v, int idx, bit sdh, bit ais, bit bp);
        @(negedge clk);
        compare();
        slot_vld = v; slot_idx = 4'(idx);
        sdh_mode = sdh; ais_force = ais; badptr_force = bp;
        if (v && idx == 0) begin
            lat_ais = ais; lat_bad = bp; lat_sdh = sdh;
        end
        if (v && idx <= 8) begin
            exp_vld  = 1;
            exp_byte = ref_byte(idx);
            if (idx != 0 && (ais != lat_ais || bp != lat_bad || sdh != lat_sdh))
                exp_tag = "R8";
            else if (lat_ais && lat_bad) exp_tag = "R7";
            else if (lat_ais) exp_tag = "R5";
            else if (lat_bad) exp_tag = "R6";
            else if (idx == 0) exp_tag = "R2";
            else if (idx <= 3) exp_tag = "R3";
            else exp_tag = "R4";
        end else begin
            exp_vld = 0;
            exp_tag = v ? "R1" : "R9";
        end
    endtask

    task automatic frame(bit sdh, bit ais, bit bp, int gap);
        for (int i = 0; i < 9; i++) begin
            drive(1, i, sdh, ais, bp);
            for (int g = 0; g < gap; g++) drive(0, 0, sdh, ais, bp);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset values while reset is held
        compare();
        rst_n = 1'b1;
        // R10: state is NORMAL/SONET before any frame start; R9 idle holds
        drive(0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 0);
        frame(0, 0, 0, 0);          // R2 R3 R4 SONET
        frame(1, 0, 0, 1);          // R2 SDH, with gaps (R9)
        frame(0, 1, 0, 0);          // R5
        frame(1, 0, 1, 2);          // R6
        frame(0, 1, 1, 0);          // R7
        // R8: controls flip mid-frame, effect only next frame
        for (int i = 0; i < 9; i++) begin
            if (i < 4) drive(1, i, 0, 0, 0);
            else       drive(1, i, 1, 1, 1);
        end
        for (int i = 0; i < 9; i++) drive(1, i, 0, 0, i > 2);
        frame(0, 0, 0, 0);
        // R1: out-of-range indices ignored, byte held
        for (int i = 9; i < 16; i++) drive(1, i, 0, 0, 0);
        drive(1, 5, 0, 0, 0);
        for (int i = 9; i < 16; i++) drive(1, i, 1, 1, 1);
        drive(0, 0, 0, 0, 0);
        @(negedge clk);
        compare();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule